// File: doc/BRIEF.md
# Serial-Lookup Set-Associative Cache with Sequential Bypass

This block is a unified instruction and data cache of 8 KB that sits between a processor request port and a simple word-wide memory port. It is organised as 128 sets of four ways, with 16-byte lines. The processor side asks for reads and writes of bytes, half-words or words. The memory side fetches whole lines on a read miss and carries every write straight through to memory. Line replacement picks a way at random. Lookups use the address exactly as presented.

To save power, the tag stores and the data store are never active together for a first access to a line. A nonsequential access spends one cycle comparing all four tags. In the next cycle it reads only the one data way that matched. This way is addressed by the set index, a 2-bit way number and the word offset. When a completed read carries the hint that the following access is sequential, and that following word is still inside the same line, the next read skips the tags entirely. It is answered in a single cycle from the way already known.

The processor holds its request steady until the ready signal is seen. The memory side also holds its request steady, until an acknowledge returns, and moves one word per acknowledge.

Top module: `seqskip_cache`

## Requirements
- R1: After reset every line is invalid. The first read of any address, including one that was cached before the reset, misses and refills.
- R2: A nonsequential read that hits raises cpu_ready in the second cycle of the request, with no memory traffic. The tags are compared in the first cycle and the one matching way is read in the second.
- R3: A read completes with cpu_seq high and word offset (address bits [3:2]) not equal to 3. The next read, to the following word, then skips the tag compare and raises cpu_ready in the first cycle of its request.
- R4: A read that completes with cpu_seq high at word offset 3 does not enable the bypass, and neither does one with cpu_seq low. The next read takes the two-cycle path.
- R5: A read miss issues four memory reads at the line-aligned address (bits [3:0] zero), with offsets 0, 4, 8 and 12 in that order. It then marks the line valid and returns the requested word one cycle after the last acknowledge, in the tenth cycle of the request when each acknowledge follows its request by one cycle. Later reads of that line hit.
- R6: cpu_size encodes 0 = byte, 1 = half-word, 2 = word. A byte read returns the byte selected by address bits [1:0] in cpu_rdata[7:0]. A half-word read returns the half selected by address bit 1 in cpu_rdata[15:0]. The upper bits are zero in both cases.
- R7: Every write produces exactly one memory write. Write data sits in the low bits of cpu_wdata and is replicated onto the byte lanes. mem_be marks the lanes chosen by size and address bits [1:0]. cpu_ready rises with mem_ack, in the third cycle of the request.
- R8: A write hit updates the cached word under the same byte enables, so a later read returns the merged word. A write miss allocates nothing, and a later read of that line refills it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 half-word, 2 word |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_seq | input | 1 | Hint: the next access follows this one sequentially |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read data, right-aligned and zero-extended |
| mem_req | output | 1 | Memory transaction request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte lane enables for writes (all ones for reads) |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read data from memory |
| mem_ack | input | 1 | Memory transaction done |

## Verification
A lost or stale valid bit shows up as an extra or missing four-word refill on the memory port. The latency of that request also changes from two cycles to ten, or the other way. If the bypass state is wrong, a read ends after one cycle where two were due, or returns a word from the wrong way at once. So the bench times every request as well as checking its data. A byte-enable error in the write merge stays hidden until the word is read back. The bench therefore rereads each written word and compares the memory image at the end.

// File: rtl/seqskip_pkg.sv
package seqskip_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_FILL, ST_WRITE} cache_st_t;

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0:    return 4'b0001 << off;
      2'd1:    return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] place_wdata(input logic [1:0] sz, input logic [WORD_W-1:0] wd);
    case (sz)
      2'd0:    return {4{wd[7:0]}};
      2'd1:    return {2{wd[15:0]}};
      default: return wd;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pick_rdata(input logic [1:0] sz, input logic [1:0] off,
                                                   input logic [WORD_W-1:0] w);
    case (sz)
      2'd0:    return {24'b0, w[{off, 3'b000} +: 8]};
      2'd1:    return {16'b0, off[1] ? w[31:16] : w[15:0]};
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/seqskip_lfsr.sv
module seqskip_lfsr #(
  parameter int          W     = 8,
  parameter int unsigned TAPS  = 32'hB8,
  parameter int          OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] pick
);
  logic [W-1:0] q;
  localparam logic [W-1:0] TAP_MASK = W'(TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= W'(1);
    else        q <= {q[W-2:0], ^(q & TAP_MASK)};
  end

  assign pick = q[OUT_W-1:0];
endmodule

// File: rtl/seqskip_tags.sv
module seqskip_tags #(
  parameter int WAYS  = 4,
  parameter int SETS  = 128,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]  hit_vec,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [WAYS*SETS-1:0] valid;
  logic [TAG_W-1:0]     tags [WAYS][SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) valid <= '0;
    else if (fill_en) valid[{fill_way, lk_idx}] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tags[fill_way][lk_idx] <= fill_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[{WAY_W'(w), lk_idx}] && (tags[w][lk_idx] == lk_tag);
  end

  // R1: a line is never resident in two ways, so at most one way matches
  a_r1_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
endmodule

// File: rtl/seqskip_data.sv
module seqskip_data #(
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int A_W   = WAY_W + IDX_W + OFF_W,
  localparam int DEPTH = WAYS * SETS * LINE_WORDS
) (
  input  logic             clk,
  input  logic [WAY_W-1:0] way,
  input  logic [IDX_W-1:0] idx,
  input  logic [OFF_W-1:0] word,
  output logic [31:0]      rd_data,
  input  logic             wr_en,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data
);
  logic [31:0] store [DEPTH];
  logic [A_W-1:0] addr;

  assign addr    = {way, idx, word};
  assign rd_data = store[addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (wr_be[b]) store[addr][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/seqskip_cache.sv
module seqskip_cache
  import seqskip_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          WAYS       = 4,
  parameter int          SETS       = 128,
  parameter int          LINE_WORDS = 4,
  parameter int          LFSR_W     = 8,
  parameter int unsigned LFSR_TAPS  = 32'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  input  logic              cpu_seq,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int IDX_W   = $clog2(SETS);
  localparam int OFF_W   = $clog2(LINE_WORDS);
  localparam int TAG_LSB = 2 + OFF_W + IDX_W;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam logic [OFF_W-1:0] WORD_LAST = OFF_W'(LINE_WORDS - 1);

  cache_st_t        state;
  logic [WAY_W-1:0] way_q;
  logic             fast_ok, wr_hit_q;
  logic [OFF_W-1:0] fill_cnt;

  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] req_word;
  logic [TAG_W-1:0] req_tag;
  assign req_idx  = cpu_addr[2+OFF_W +: IDX_W];
  assign req_word = cpu_addr[2 +: OFF_W];
  assign req_tag  = cpu_addr[ADDR_W-1:TAG_LSB];

  // named internal events
  logic fast_hit, tag_lookup, data_rd_en, fill_beat, fill_done, wr_merge;
  assign fast_hit   = (state == ST_IDLE) && cpu_req && fast_ok && !cpu_we;
  assign tag_lookup = (state == ST_IDLE) && cpu_req && !(fast_ok && !cpu_we);
  assign data_rd_en = fast_hit || (state == ST_DATA);
  assign fill_beat  = (state == ST_FILL) && mem_ack;
  assign fill_done  = fill_beat && (fill_cnt == WORD_LAST);
  assign wr_merge   = (state == ST_WRITE) && mem_ack && wr_hit_q;

  logic [WAYS-1:0]  hit_vec;
  logic             hit_any;
  logic [WAY_W-1:0] hit_way, victim;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end
  assign hit_any = |hit_vec;

  seqskip_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_idx(req_idx), .lk_tag(req_tag), .hit_vec(hit_vec),
    .fill_en(fill_done), .fill_way(way_q), .fill_tag(req_tag)
  );

  seqskip_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .OUT_W(WAY_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .pick(victim)
  );

  logic [31:0] rd_word, wr_word;
  logic [3:0]  wr_be;
  assign wr_word = (state == ST_FILL) ? mem_rdata : place_wdata(cpu_size, cpu_wdata);
  assign wr_be   = (state == ST_FILL) ? 4'hF : lane_mask(cpu_size, cpu_addr[1:0]);

  seqskip_data #(.WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk(clk), .way(way_q), .idx(req_idx),
    .word((state == ST_FILL) ? fill_cnt : req_word),
    .rd_data(rd_word), .wr_en(fill_beat || wr_merge), .wr_be(wr_be), .wr_data(wr_word)
  );

  assign cpu_ready = data_rd_en || ((state == ST_WRITE) && mem_ack);
  assign cpu_rdata = pick_rdata(cpu_size, cpu_addr[1:0], rd_word);

  assign mem_req   = (state == ST_FILL) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = (state == ST_FILL) ? {cpu_addr[ADDR_W-1:2+OFF_W], fill_cnt, 2'b00}
                                        : {cpu_addr[ADDR_W-1:2], 2'b00};
  assign mem_be    = (state == ST_WRITE) ? lane_mask(cpu_size, cpu_addr[1:0]) : 4'hF;
  assign mem_wdata = place_wdata(cpu_size, cpu_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      way_q    <= '0;
      fast_ok  <= 1'b0;
      wr_hit_q <= 1'b0;
      fill_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fast_hit) begin
            fast_ok <= cpu_seq && (req_word != WORD_LAST);
          end else if (tag_lookup) begin
            way_q    <= hit_any ? hit_way : victim;
            wr_hit_q <= hit_any;
            fill_cnt <= '0;
            fast_ok  <= 1'b0;
            state    <= cpu_we ? ST_WRITE : (hit_any ? ST_DATA : ST_FILL);
          end
        end
        ST_DATA: begin
          fast_ok <= cpu_seq && (req_word != WORD_LAST);
          state   <= ST_IDLE;
        end
        ST_FILL: begin
          if (mem_ack) begin
            fill_cnt <= fill_cnt + 1'b1;
            if (fill_cnt == WORD_LAST) state <= ST_DATA;
          end
        end
        default: begin
          if (mem_ack) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R2: a tag hit on a read is answered in the following cycle
  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_lookup && hit_any && !cpu_we) |=> cpu_ready);

  // R3: a hinted in-line completion lets the next read bypass the tags
  a_r3_seq_skips_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_we && cpu_seq && (req_word != WORD_LAST)) |=> (cpu_we || !tag_lookup));

  // R5: refill reads stay inside the requested line and are word aligned
  a_r5_fill_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> ((mem_addr[ADDR_W-1:2+OFF_W] == cpu_addr[ADDR_W-1:2+OFF_W]) &&
                              (mem_addr[1:0] == 2'b00)));

  // R7: a write lookup is followed by a memory write
  a_r7_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_lookup && cpu_we) |=> (mem_req && mem_we));
endmodule

// File: tb/seqskip_cache_tb.sv
module seqskip_cache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cpu_req = 0, cpu_we = 0, cpu_seq = 0;
  logic [1:0]  cpu_size = 2'd2;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  seqskip_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_seq(cpu_seq), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_chk = 0, n_bad = 0;
  int n_rd = 0, n_wr = 0;
  logic [31:0] rd_log [4];

  logic [31:0] resp_mem [4096];
  logic [31:0] exp_mem  [4096];

  function automatic logic [31:0] seed_word(input int i);
    return {16'(i * 7 + 16'h1234), 16'(~i)};
  endfunction

  // memory responder: one-cycle acknowledge, then one idle cycle
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) resp_mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        n_wr <= n_wr + 1;
      end else begin
        if (n_rd < 4) rd_log[n_rd] <= mem_addr;
        n_rd <= n_rd + 1;
      end
    end
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= resp_mem[mem_addr[13:2]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input logic sq,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd; cpu_seq = sq;
    cyc = 1;
    #1;
    while (!cpu_ready && cyc < 64) begin
      @(negedge clk); #1; cyc++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0; cpu_seq = 0;
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [31:0] a);
    logic [31:0] w = exp_mem[a[13:2]];
    if (sz == 2'd0) return (w >> (a[1:0] * 8)) & 32'hFF;
    if (sz == 2'd1) return (w >> (a[1] * 16)) & 32'hFFFF;
    return w;
  endfunction

  task automatic exp_write(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd);
    int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    int lo = (sz == 2'd0) ? a[1:0] : (sz == 2'd1) ? a[1] * 2 : 0;
    for (int k = 0; k < nb; k++) exp_mem[a[13:2]][8*(lo+k) +: 8] = wd[8*k +: 8];
  endtask

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        seq;
    logic [7:0]  cyc;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 32'h0000_0100, 32'h0, 1'b0, 8'd10}, // R5 R1 cold miss
    '{1'b0, 2'd2, 32'h0000_0104, 32'h0, 1'b1, 8'd2},  // R2 hit, no bypass yet
    '{1'b0, 2'd2, 32'h0000_0108, 32'h0, 1'b1, 8'd1},  // R3 bypass
    '{1'b0, 2'd2, 32'h0000_010C, 32'h0, 1'b1, 8'd1},  // R3 bypass, last word
    '{1'b0, 2'd2, 32'h0000_0100, 32'h0, 1'b0, 8'd2},  // R4 no bypass after word 3
    '{1'b0, 2'd0, 32'h0000_0105, 32'h0, 1'b0, 8'd2},  // R6 byte
    '{1'b0, 2'd1, 32'h0000_010E, 32'h0, 1'b0, 8'd2},  // R6 upper half
    '{1'b1, 2'd2, 32'h0000_0104, 32'hDEADBEEF, 1'b0, 8'd3}, // R7 write hit
    '{1'b0, 2'd2, 32'h0000_0104, 32'h0, 1'b1, 8'd2},  // R8 reread
    '{1'b0, 2'd2, 32'h0000_0108, 32'h0, 1'b0, 8'd1},  // R3 bypass after write
    '{1'b1, 2'd0, 32'h0000_0107, 32'h0000_00C3, 1'b0, 8'd3}, // R7 byte write
    '{1'b0, 2'd2, 32'h0000_0104, 32'h0, 1'b0, 8'd2},  // R8 merged word
    '{1'b1, 2'd2, 32'h0000_2000, 32'h12345678, 1'b0, 8'd3}, // R8 write miss
    '{1'b0, 2'd2, 32'h0000_2000, 32'h0, 1'b1, 8'd10}, // R8 no allocation -> refill
    '{1'b0, 2'd2, 32'h0000_2004, 32'h0, 1'b1, 8'd1},  // R3
    '{1'b0, 2'd1, 32'h0000_2008, 32'h0, 1'b0, 8'd1}   // R3 R6 low half via bypass
  };

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    for (int i = 0; i < 4096; i++) begin
      resp_mem[i] = seed_word(i);
      exp_mem[i]  = seed_word(i);
    end
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset ready", {31'b0, cpu_ready}, 32'd0);
    check("R1 reset mem_req", {31'b0, mem_req}, 32'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    check("R1 idle ready", {31'b0, cpu_ready}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      access(VECS[v].we, VECS[v].sz, VECS[v].addr, VECS[v].wd, VECS[v].seq, rd, cyc);
      check($sformatf("R2-R8 vec%0d cycles", v), 32'(cyc), 32'(VECS[v].cyc));
      if (VECS[v].we) exp_write(VECS[v].sz, VECS[v].addr, VECS[v].wd);
      else check($sformatf("R6 R8 vec%0d data", v), rd, exp_read(VECS[v].sz, VECS[v].addr));
      if (v == 0) begin
        check("R5 fill beats", 32'(n_rd), 32'd4);
        for (int k = 0; k < 4; k++)
          check("R5 fill order", rd_log[k], 32'h100 + 32'(4 * k));
      end
    end
    check("R2 R8 total mem reads", 32'(n_rd), 32'd8);
    check("R7 total mem writes", 32'(n_wr), 32'd3);
    check("R7 mem image 0x104", resp_mem[12'h041], exp_mem[12'h041]);
    check("R7 mem image 0x2000", resp_mem[12'h800], exp_mem[12'h800]);

    // R1: reset again, a previously cached line must miss
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    access(1'b0, 2'd2, 32'h0000_0104, 32'h0, 1'b0, rd, cyc);
    check("R1 miss after reset cycles", 32'(cyc), 32'd10);
    check("R1 miss after reset data", rd, exp_mem[12'h041]);
    access(1'b0, 2'd0, 32'h0000_0104, 32'h0, 1'b0, rd, cyc);
    check("R6 byte lane 0", rd, exp_read(2'd0, 32'h104));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule